// File: doc/BRIEF.md
# SCSI Initiator Control Register File

This block sits between a host processor and the control side of a SCSI bus interface, in the initiator role. The host reaches sixteen byte-wide locations through a simple register strobe. Writes drive the initiator's bus lines, latch outgoing data, set the chip mode and fire one-cycle DMA start requests. Reads return either stored control bytes or status bytes that are built live from the bus lines and the current information-transfer phase.

The same address can name two different registers depending on direction. Address 0 writes the outgoing data latch but reads the live bus data. Addresses 5, 6 and 7 start DMA operations on a write but read bus-and-status, the input latch and a flag-clear location. A small tracker follows the bus mode (free, arbitrate, select) from the host's writes. A phase-match flag compares the host's expected phase with the phase the target is driving.

The host port is a plain register strobe (`host_sel` with `host_wr`). Every access completes in the cycle it is presented, so there is no back-pressure. Read data is combinational on the presented address. Write effects appear on the outputs after the clock edge that takes the write.

Top module: `scsi_init_regs`

## Requirements
- R1: Reset clears every drive output, `out_data`, `dma_mode`, `drq` and the three DMA start pulses, and puts `bus_mode` in free (encoding free=0, arbitrate=1, select=2).
- R2: A write to address 1 sets, after the edge, `data_drive_en` from bit 0, `drv_atn` from bit 1, `drv_sel` from bit 2, `drv_bsy` from bit 3, `drv_ack` from bit 4 and `drv_rst` from bit 7.
- R3: Reads of addresses 1, 2 and 3 return the last byte written there. Addresses 8 to 15 read as zero, and writes to them change no output or register.
- R4: On an address-1 write, the mode goes to free if the new SEL, the new BSY and `tgt_busy` are all low. Otherwise, if the new SEL is high and the mode is arbitrate, it goes to select. In every other case it is unchanged, so free never jumps straight to select.
- R5: A write to address 2 with bit 0 set moves the mode from free to arbitrate. In any other mode that bit is ignored.
- R6: Address-2 bit 1 is `dma_mode`. A `drq_set` pulse raises `drq` only while `dma_mode` is 1, and writing bit 1 as 0 drops `drq`.
- R7: A read of address 4 returns {RST, BSY or `tgt_busy`, `bus_req`, `bus_msg`, `bus_cd`, `bus_io`, SEL, 0} from bit 7 down to bit 0. RST, BSY and SEL are the driven values.
- R8: A read of address 5 returns ACK in bit 0, ATN in bit 1, busy-error in bit 2, phase-match in bit 3, interrupt in bit 4, parity-error in bit 5, `drq` in bit 6, and 0 in bit 7.
- R9: Phase-match is 1 exactly when bits 2:0 of the address-3 byte equal {`bus_msg`, `bus_cd`, `bus_io`}.
- R10: A write to address 0 sets `out_data`. A read of address 0 returns the live `bus_data_in`.
- R11: A read of address 6 returns the `bus_data_in` value captured on the last rising edge of `bus_req`. It holds while `bus_req` stays high.
- R12: A write to address 5, 6 or 7 gives a single-cycle pulse on `dma_send_go`, `dma_trecv_go` or `dma_irecv_go` respectively. At most one pulse is high at a time.
- R13: The set inputs `par_err_set`, `irq_set` and `busy_err_set` raise their flags. A read of address 7 returns 0 and clears all three flags, unless a set arrives in the same cycle, in which case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the presented address |
| bus_data_in | input | 8 | Live SCSI data lines |
| bus_req | input | 1 | Target REQ line |
| bus_msg | input | 1 | Target MSG phase line |
| bus_cd | input | 1 | Target C/D phase line |
| bus_io | input | 1 | Target I/O phase line |
| tgt_busy | input | 1 | Target holding BSY |
| drq_set | input | 1 | DMA request from the transfer engine |
| par_err_set | input | 1 | Sets the parity-error flag |
| irq_set | input | 1 | Sets the interrupt flag |
| busy_err_set | input | 1 | Sets the busy-error flag |
| data_drive_en | output | 1 | Enable for driving the data lines |
| drv_atn | output | 1 | ATN drive |
| drv_sel | output | 1 | SEL drive |
| drv_bsy | output | 1 | BSY drive |
| drv_ack | output | 1 | ACK drive |
| drv_rst | output | 1 | RST drive |
| out_data | output | 8 | Outgoing data latch |
| dma_mode | output | 1 | DMA mode bit |
| drq | output | 1 | DMA request flag |
| bus_mode | output | 2 | 0 free, 1 arbitrate, 2 select |
| dma_send_go | output | 1 | Start DMA send pulse |
| dma_trecv_go | output | 1 | Start target-receive pulse |
| dma_irecv_go | output | 1 | Start initiator-receive pulse |

## Verification
The bench targets the shared read/write addresses. A design that swapped the meanings at address 0 or 5 would return the outgoing latch instead of live data, or would fire a DMA pulse on a status read. It walks the mode tracker through arbitrate-to-select, a SEL write from free, a BSY-only write in select and a write with the target still busy. A tracker with the conditions wrong would leave select early or enter it without arbitrating. It also checks that `drq` cannot rise outside DMA mode, that the input latch holds while REQ stays high, and that a read of address 7 clears exactly the three flags without disturbing ATN or phase-match.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ARB  = 2'd1,
    MODE_SEL  = 2'd2
  } bus_mode_e;

  localparam int A_DATA  = 0;
  localparam int A_ICMD  = 1;
  localparam int A_MODE  = 2;
  localparam int A_TCMD  = 3;
  localparam int A_STAT  = 4;
  localparam int A_BSTAT = 5;
  localparam int A_INLAT = 6;
  localparam int A_CLR   = 7;
  localparam int A_GO0   = 5;
  localparam int NGO     = 3;

  localparam int IC_DRV = 0;
  localparam int IC_ATN = 1;
  localparam int IC_SEL = 2;
  localparam int IC_BSY = 3;
  localparam int IC_ACK = 4;
  localparam int IC_RST = 7;
  localparam int MD_ARB = 0;
  localparam int MD_DMA = 1;
endpackage

// File: rtl/scsi_ctl_decode.sv
module scsi_ctl_decode
  import scsi_regs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          drq_set,
  output logic [DW-1:0] icmd_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] tcmd_q,
  output logic [DW-1:0] odata_q,
  output logic [NGO-1:0] go_q,
  output logic          drq_q
);
  logic [NGO-1:0] go_hit;
  logic           drop_drq;

  for (genvar g = 0; g < NGO; g++) begin : g_go
    assign go_hit[g] = wr_stb && (addr == AW'(A_GO0 + g));
  end

  assign drop_drq = wr_stb && (addr == AW'(A_MODE)) && !wdata[MD_DMA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icmd_q  <= '0;
      mode_q  <= '0;
      tcmd_q  <= '0;
      odata_q <= '0;
      go_q    <= '0;
      drq_q   <= 1'b0;
    end else begin
      go_q <= go_hit;
      if (wr_stb) begin
        case (addr)
          AW'(A_DATA): odata_q <= wdata;
          AW'(A_ICMD): icmd_q  <= wdata;
          AW'(A_MODE): mode_q  <= wdata;
          AW'(A_TCMD): tcmd_q  <= wdata;
          default: ;
        endcase
      end
      if (drop_drq)
        drq_q <= 1'b0;
      else if (drq_set && mode_q[MD_DMA])
        drq_q <= 1'b1;
    end
  end

  p_go_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(go_q));

  p_go_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q != '0) |=> (go_q == '0) || $past(wr_stb));

  p_drq_needs_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[MD_DMA] |-> !drq_q);
endmodule

// File: rtl/scsi_mode_tracker.sv
module scsi_mode_tracker
  import scsi_regs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_icmd,
  input  logic      wr_mode,
  input  logic      new_sel,
  input  logic      new_bsy,
  input  logic      arb_req,
  input  logic      tgt_busy,
  output bus_mode_e mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_FREE;
    end else if (wr_icmd) begin
      if (!(new_sel || new_bsy || tgt_busy))
        mode <= MODE_FREE;
      else if (new_sel && mode == MODE_ARB)
        mode <= MODE_SEL;
    end else if (wr_mode && arb_req && mode == MODE_FREE) begin
      mode <= MODE_ARB;
    end
  end

  p_sel_via_arb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SEL && $past(mode) != MODE_SEL) |-> $past(mode) == MODE_ARB);

  p_arb_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ARB && $past(mode) != MODE_ARB) |-> $past(wr_mode && arb_req));

  p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

// File: rtl/scsi_status_compose.sv
module scsi_status_compose
  import scsi_regs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_data_in,
  input  logic          bus_req,
  input  logic          bus_msg,
  input  logic          bus_cd,
  input  logic          bus_io,
  input  logic          tgt_busy,
  input  logic          par_err_set,
  input  logic          irq_set,
  input  logic          busy_err_set,
  input  logic [DW-1:0] icmd_q,
  input  logic [DW-1:0] mode_q,
  input  logic [DW-1:0] tcmd_q,
  input  logic          drq_q,
  output logic [DW-1:0] rdata
);
  logic          par_q, irq_q, berr_q, req_q;
  logic [DW-1:0] inlat_q;
  logic          phase_hit, clr_rd;

  assign phase_hit = (tcmd_q[2:0] == {bus_msg, bus_cd, bus_io});
  assign clr_rd    = rd_stb && (addr == AW'(A_CLR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q   <= 1'b0;
      irq_q   <= 1'b0;
      berr_q  <= 1'b0;
      req_q   <= 1'b0;
      inlat_q <= '0;
    end else begin
      req_q <= bus_req;
      if (bus_req && !req_q) inlat_q <= bus_data_in;
      par_q  <= par_err_set  || (par_q  && !clr_rd);
      irq_q  <= irq_set      || (irq_q  && !clr_rd);
      berr_q <= busy_err_set || (berr_q && !clr_rd);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_DATA):  rdata = bus_data_in;
      AW'(A_ICMD):  rdata = icmd_q;
      AW'(A_MODE):  rdata = mode_q;
      AW'(A_TCMD):  rdata = tcmd_q;
      AW'(A_STAT):  rdata = {icmd_q[IC_RST], icmd_q[IC_BSY] | tgt_busy, bus_req,
                             bus_msg, bus_cd, bus_io, icmd_q[IC_SEL], 1'b0};
      AW'(A_BSTAT): rdata = {1'b0, drq_q, par_q, irq_q, phase_hit, berr_q,
                             icmd_q[IC_ATN], icmd_q[IC_ACK]};
      AW'(A_INLAT): rdata = inlat_q;
      default:      rdata = '0;
    endcase
  end

  p_clear_on_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !par_err_set && !irq_set && !busy_err_set)
      |=> !par_q && !irq_q && !berr_q);

  p_latch_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_q) |-> $stable(inlat_q));
endmodule

// File: rtl/scsi_init_regs.sv
module scsi_init_regs
  import scsi_regs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] bus_data_in,
  input  logic          bus_req,
  input  logic          bus_msg,
  input  logic          bus_cd,
  input  logic          bus_io,
  input  logic          tgt_busy,
  input  logic          drq_set,
  input  logic          par_err_set,
  input  logic          irq_set,
  input  logic          busy_err_set,
  output logic          data_drive_en,
  output logic          drv_atn,
  output logic          drv_sel,
  output logic          drv_bsy,
  output logic          drv_ack,
  output logic          drv_rst,
  output logic [DW-1:0] out_data,
  output logic          dma_mode,
  output logic          drq,
  output logic [1:0]    bus_mode,
  output logic          dma_send_go,
  output logic          dma_trecv_go,
  output logic          dma_irecv_go
);
  logic           wr_stb, rd_stb;
  logic [DW-1:0]  icmd_q, mode_q, tcmd_q;
  logic [NGO-1:0] go_q;
  bus_mode_e      mode;

  assign wr_stb = host_sel && host_wr;
  assign rd_stb = host_sel && !host_wr;

  scsi_ctl_decode #(.DW(DW), .AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(host_addr),
    .wdata(host_wdata), .drq_set(drq_set), .icmd_q(icmd_q), .mode_q(mode_q),
    .tcmd_q(tcmd_q), .odata_q(out_data), .go_q(go_q), .drq_q(drq)
  );

  scsi_mode_tracker u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_icmd(wr_stb && host_addr == AW'(A_ICMD)),
    .wr_mode(wr_stb && host_addr == AW'(A_MODE)),
    .new_sel(host_wdata[IC_SEL]), .new_bsy(host_wdata[IC_BSY]),
    .arb_req(host_wdata[MD_ARB]), .tgt_busy(tgt_busy), .mode(mode)
  );

  scsi_status_compose #(.DW(DW), .AW(AW)) u_stat (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr(host_addr),
    .bus_data_in(bus_data_in), .bus_req(bus_req), .bus_msg(bus_msg),
    .bus_cd(bus_cd), .bus_io(bus_io), .tgt_busy(tgt_busy),
    .par_err_set(par_err_set), .irq_set(irq_set), .busy_err_set(busy_err_set),
    .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q), .drq_q(drq),
    .rdata(host_rdata)
  );

  assign data_drive_en = icmd_q[IC_DRV];
  assign drv_atn       = icmd_q[IC_ATN];
  assign drv_sel       = icmd_q[IC_SEL];
  assign drv_bsy       = icmd_q[IC_BSY];
  assign drv_ack       = icmd_q[IC_ACK];
  assign drv_rst       = icmd_q[IC_RST];
  assign dma_mode      = mode_q[MD_DMA];
  assign bus_mode      = mode;
  assign dma_send_go   = go_q[0];
  assign dma_trecv_go  = go_q[1];
  assign dma_irecv_go  = go_q[2];

  p_icmd_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && host_addr == AW'(A_ICMD)) |=>
      {drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, data_drive_en} ==
      {$past(host_wdata[7]), $past(host_wdata[4:0])});

  p_high_addr_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && host_addr[AW-1]) |=> $stable(out_data) && $stable(bus_mode));
endmodule

// File: tb/scsi_init_regs_test.sv
module scsi_init_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 0, host_wr = 0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata, bus_data_in = '0, out_data;
  logic bus_req = 0, bus_msg = 0, bus_cd = 0, bus_io = 0, tgt_busy = 0;
  logic drq_set = 0, par_err_set = 0, irq_set = 0, busy_err_set = 0;
  logic data_drive_en, drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst;
  logic dma_mode, drq, dma_send_go, dma_trecv_go, dma_irecv_go;
  logic [1:0] bus_mode;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  scsi_init_regs uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic settle;
    #5;
  endtask

  // monitor: compares read data against the scoreboard queue
  always begin
    @(negedge clk);
    #5;
    if (host_sel && !host_wr) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: read with empty queue actual %0h expected none", host_rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk({24'h0, host_rdata}, {24'h0, it.exp}, it.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk({data_drive_en, drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst}, 0, "R1 drives after reset");
    chk({out_data, dma_mode, drq, dma_send_go, dma_trecv_go, dma_irecv_go}, 0, "R1 data/dma after reset");
    chk(bus_mode, 0, "R1 mode free after reset");

    bus_data_in = 8'h5A;
    rd(4'd0, 8'h5A, "R10 live data read");
    wr(4'd0, 8'hC3); settle();
    chk(out_data, 8'hC3, "R10 out_data write");

    wr(4'd1, 8'h9F); settle();
    chk({drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, data_drive_en}, 6'b111111, "R2 icmd all set");
    chk(bus_mode, 0, "R4 no free-to-select");
    rd(4'd1, 8'h9F, "R3 icmd readback");
    wr(4'd1, 8'h12); settle();
    chk({drv_rst, drv_ack, drv_bsy, drv_sel, drv_atn, data_drive_en}, 6'b010010, "R2 icmd ack+atn");
    wr(4'd1, 8'h00); settle();
    chk(bus_mode, 0, "R4 all idle -> free");

    wr(4'd2, 8'h01); settle();
    chk(bus_mode, 1, "R5 free -> arbitrate");
    rd(4'd2, 8'h01, "R3 mode readback");
    wr(4'd1, 8'h04); settle();
    chk(bus_mode, 2, "R4 arbitrate -> select");
    wr(4'd2, 8'h01); settle();
    chk(bus_mode, 2, "R5 arb bit ignored in select");
    wr(4'd1, 8'h08); settle();
    chk(bus_mode, 2, "R4 bsy only keeps select");
    tgt_busy = 1;
    wr(4'd1, 8'h00); settle();
    chk(bus_mode, 2, "R4 target busy keeps select");
    tgt_busy = 0;
    wr(4'd1, 8'h00); settle();
    chk(bus_mode, 0, "R4 back to free");

    @(negedge clk); drq_set = 1; @(negedge clk); drq_set = 0; settle();
    chk(drq, 0, "R6 drq blocked outside dma mode");
    wr(4'd2, 8'h02); settle();
    chk({dma_mode, bus_mode}, 3'b100, "R6 dma mode on, mode free");
    @(negedge clk); drq_set = 1; @(negedge clk); drq_set = 0; settle();
    chk(drq, 1, "R6 drq set in dma mode");
    rd(4'd5, 8'h48, "R8 drq bit6 and phase match bit3");
    wr(4'd2, 8'h00); settle();
    chk({dma_mode, drq}, 0, "R6 clearing dma drops drq");

    bus_data_in = 8'hA7;
    bus_msg = 1; bus_cd = 0; bus_io = 1; tgt_busy = 1;
    @(negedge clk); bus_req = 1;
    wr(4'd1, 8'h86);
    rd(4'd4, 8'hF6, "R7 bus status compose");
    wr(4'd3, 8'h05);
    rd(4'd5, 8'h0A, "R9 phase match set");
    wr(4'd3, 8'h04);
    rd(4'd5, 8'h02, "R9 phase mismatch");
    rd(4'd3, 8'h04, "R3 tcmd readback");
    tgt_busy = 0;

    rd(4'd6, 8'hA7, "R11 latch on req rise");
    bus_data_in = 8'h11;
    rd(4'd6, 8'hA7, "R11 latch holds while req high");
    @(negedge clk); bus_req = 0;
    @(negedge clk); bus_data_in = 8'h3C; bus_req = 1;
    @(negedge clk);
    rd(4'd6, 8'h3C, "R11 new capture");
    rd(4'd0, 8'h3C, "R10 live data after change");

    @(negedge clk); par_err_set = 1; @(negedge clk); par_err_set = 0; irq_set = 1;
    @(negedge clk); irq_set = 0; busy_err_set = 1; @(negedge clk); busy_err_set = 0;
    rd(4'd5, 8'h36, "R13 flags set");
    rd(4'd7, 8'h00, "R13 clear read value");
    rd(4'd5, 8'h02, "R13 flags cleared, atn kept");

    wr(4'd5, 8'hFF); settle();
    chk({dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b100, "R12 send pulse");
    @(negedge clk); settle();
    chk({dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b000, "R12 send pulse one cycle");
    wr(4'd6, 8'h00); settle();
    chk({dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b010, "R12 target receive pulse");
    wr(4'd7, 8'h00); settle();
    chk({dma_send_go, dma_trecv_go, dma_irecv_go}, 3'b001, "R12 initiator receive pulse");

    wr(4'd9, 8'hFF); settle();
    chk({out_data, drv_rst, drv_sel, bus_mode}, {8'hC3, 1'b1, 1'b1, 2'b00}, "R3 high address write inert");
    rd(4'd9, 8'h00, "R3 high address reads zero");
    rd(4'd1, 8'h86, "R3 icmd untouched");

    @(negedge clk); rst_n = 0;
    @(negedge clk); settle();
    chk({data_drive_en, drv_atn, drv_sel, drv_bsy, drv_ack, drv_rst, out_data}, 0, "R1 mid-run reset");
    @(negedge clk); rst_n = 1;

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule